// File: doc/BRIEF.md
# Interrupt and Trap Program-Counter Sequencer

This block is the next-PC control of a small fetch-execute processor. After each completed instruction it moves the program counter forward by one instruction step. It can also leave that sequence in three ways, each through one word in memory:

- **Device interrupt.** When interrupts are enabled, a pending request is taken after the advance. The block turns further interrupts off, stores the advanced PC in a fixed save word, and loads the handler address from a fixed handler word.
- **Trap.** A trap with number n reads the PC from a table entry at a fixed base plus n. The same clock edge puts the processor in supervisor mode.
- **Return.** A return restores the PC from the save word, turns interrupts back on and drops to user mode.

Each memory access is a request held until a one-cycle acknowledge arrives. While any vector or save access is in flight, the sequencer is busy and ignores all strobes and the interrupt line. This keeps each multi-step dispatch indivisible. A halt strobe freezes the sequencer until reset. The instruction decoder, the ALU and the memory array lie outside the block.

Top module: `irq_trap_seq`

## Requirements
- R1: After reset the PC equals START_PC (0x0100 by default), supervisor mode is selected (sup_mode=1), interrupts are disabled (int_en=0), halted=0, busy=0 and mem_req=0.
- R2: An instr_done strobe while idle and not halted, and with no interrupt taken, gives PC = PC + STEP (default STEP=1) on the next cycle, with no memory access.
- R3: A halt_req strobe sets halted from the next cycle. From then on, until reset, instr_done, trap_req and rti_req change neither the PC nor the mode, and start no memory access.
- R4: An instr_done while int_en=1 and irq_req=1 does four things. It advances the PC and clears int_en on the same edge. It then writes the advanced PC to word SAVE_ADDR (0). Finally it reads word HANDLER_ADDR (1) and loads the PC from that word. The mode stays unchanged.
- R5: irq_req has no effect while int_en=0. The instruction only advances the PC.
- R6: A trap_req with number n reads word TRAP_BASE+n (default base 1000). On the acknowledge, the PC takes the read data and sup_mode becomes 1 on that same edge.
- R7: While busy=1, every strobe and irq_req is ignored. The PC and the mode change only as the running sequence dictates.
- R8: An rti_req reads word SAVE_ADDR. On the acknowledge, the PC takes the read data, int_en becomes 1 and sup_mode becomes 0, all on the same edge.
- R9: mem_req stays high, with mem_addr and mem_we unchanged, until a cycle with mem_ack=1. The read data is used only in that cycle.
- R10: When several strobes arrive in one idle cycle, rti_req wins over trap_req, and trap_req wins over instr_done. The losing strobes are dropped.
- R11: sup_mode rises only on the acknowledge of a trap-table read. int_en rises only on the acknowledge of a read of the save word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_done | input | 1 | Current instruction has completed |
| trap_req | input | 1 | Trap instruction executed |
| trap_num | input | TW | Trap number, indexes the trap table |
| rti_req | input | 1 | Return-from-interrupt executed |
| irq_req | input | 1 | Device interrupt request (level) |
| halt_req | input | 1 | Set the halt flag |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address of the access |
| mem_wdata | output | AW | Write data (saved PC) |
| mem_ack | input | 1 | One-cycle acknowledge; read data valid with it |
| mem_rdata | input | AW | Read data |
| pc | output | AW | Program counter |
| sup_mode | output | 1 | 1 = supervisor, 0 = user |
| int_en | output | 1 | Interrupts enabled |
| halted | output | 1 | Halt flag |
| busy | output | 1 | A vector/save/restore sequence is in flight |

## Verification
The PC-sequencing function is driven through a chain of steps, traps and returns. Each link in the chain starts from the state the previous link left, so a wrong vector address, a stale save word or a missed mode change shows up as a wrong PC later in the chain. Steps with the interrupt line raised are run both with interrupts disabled and with them enabled. That pairing separates an ignored request from a serviced one. Traps to the first, a middle and the last table entry separate a correct table index from one that is off by one or truncated. Same-cycle strobe combinations, together with strobes raised during a slow memory access, separate the priority order from leakage of strobes into a busy sequence.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_SAVE,
    ST_HVEC,
    ST_TVEC,
    ST_RLOAD
  } seq_state_e;

  typedef enum logic [1:0] {
    VA_SAVE,
    VA_HANDLER,
    VA_TRAP
  } vec_sel_e;

endpackage

// File: rtl/seq_vec_addr.sv
module seq_vec_addr
  import seq_pkg::*;
#(
  parameter int AW           = 16,
  parameter int TW           = 4,
  parameter int SAVE_ADDR    = 0,
  parameter int HANDLER_ADDR = 1,
  parameter int TRAP_BASE    = 1000
) (
  input  vec_sel_e        sel,
  input  logic [TW-1:0]   trap_num,
  output logic [AW-1:0]   addr
);

  localparam int              TBL_SIZE = 1 << TW;
  localparam bit              ALIGNED  = (TRAP_BASE % TBL_SIZE) == 0;
  localparam logic [AW-1:0]   BASE_V   = AW'(TRAP_BASE);

  logic [AW-1:0] trap_addr;

  generate
    if (ALIGNED) begin : g_concat
      assign trap_addr = {BASE_V[AW-1:TW], trap_num};
    end else begin : g_add
      assign trap_addr = BASE_V + AW'(trap_num);
    end
  endgenerate

  always_comb begin
    case (sel)
      VA_HANDLER: addr = AW'(HANDLER_ADDR);
      VA_TRAP:    addr = trap_addr;
      default:    addr = AW'(SAVE_ADDR);
    endcase
  end

endmodule

// File: rtl/seq_mem_port.sv
module seq_mem_port #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_we,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] start_wdata,
  input  logic          mem_ack,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  output logic          done
);

  assign done = mem_req & mem_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (start) begin
      mem_req   <= 1'b1;
      mem_we    <= start_we;
      mem_addr  <= start_addr;
      mem_wdata <= start_wdata;
    end else if (done) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
    end
  end

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import seq_pkg::*;
#(
  parameter int AW       = 16,
  parameter int START_PC = 256,
  parameter int STEP     = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          instr_done,
  input  logic          trap_req,
  input  logic          rti_req,
  input  logic          irq_req,
  input  logic          halt_req,
  input  logic          mem_done,
  input  logic [AW-1:0] mem_rdata,
  output logic          start,
  output logic          start_we,
  output vec_sel_e      vec_sel,
  output logic [AW-1:0] pc_next_seq,
  output logic [AW-1:0] pc,
  output logic          sup_mode,
  output logic          int_en,
  output logic          halted,
  output logic          busy
);

  seq_state_e state;
  logic       idle_ok;
  logic       take_irq;

  assign pc_next_seq = pc + AW'(STEP);
  assign busy        = (state != ST_RUN);
  assign idle_ok     = (state == ST_RUN) && !halted;
  assign take_irq    = instr_done && irq_req && int_en;

  always_comb begin
    start    = 1'b0;
    start_we = 1'b0;
    vec_sel  = VA_SAVE;
    if (idle_ok) begin
      if (rti_req) begin
        start = 1'b1;
      end else if (trap_req) begin
        start   = 1'b1;
        vec_sel = VA_TRAP;
      end else if (take_irq) begin
        start    = 1'b1;
        start_we = 1'b1;
      end
    end else if (state == ST_SAVE && mem_done) begin
      start   = 1'b1;
      vec_sel = VA_HANDLER;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_RUN;
      pc       <= AW'(START_PC);
      sup_mode <= 1'b1;
      int_en   <= 1'b0;
      halted   <= 1'b0;
    end else begin
      if (halt_req) halted <= 1'b1;
      case (state)
        ST_RUN: begin
          if (!halted) begin
            if (rti_req) begin
              state <= ST_RLOAD;
            end else if (trap_req) begin
              state <= ST_TVEC;
            end else if (instr_done) begin
              pc <= pc_next_seq;
              if (take_irq) begin
                int_en <= 1'b0;
                state  <= ST_SAVE;
              end
            end
          end
        end
        ST_SAVE: begin
          if (mem_done) state <= ST_HVEC;
        end
        ST_HVEC: begin
          if (mem_done) begin
            pc    <= mem_rdata;
            state <= ST_RUN;
          end
        end
        ST_TVEC: begin
          if (mem_done) begin
            pc       <= mem_rdata;
            sup_mode <= 1'b1;
            state    <= ST_RUN;
          end
        end
        ST_RLOAD: begin
          if (mem_done) begin
            pc       <= mem_rdata;
            int_en   <= 1'b1;
            sup_mode <= 1'b0;
            state    <= ST_RUN;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

endmodule

// File: rtl/irq_trap_seq.sv
module irq_trap_seq
  import seq_pkg::*;
#(
  parameter int AW           = 16,
  parameter int TW           = 4,
  parameter int START_PC     = 256,
  parameter int STEP         = 1,
  parameter int SAVE_ADDR    = 0,
  parameter int HANDLER_ADDR = 1,
  parameter int TRAP_BASE    = 1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          instr_done,
  input  logic          trap_req,
  input  logic [TW-1:0] trap_num,
  input  logic          rti_req,
  input  logic          irq_req,
  input  logic          halt_req,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_rdata,
  output logic [AW-1:0] pc,
  output logic          sup_mode,
  output logic          int_en,
  output logic          halted,
  output logic          busy
);

  logic          start;
  logic          start_we;
  vec_sel_e      vec_sel;
  logic [AW-1:0] start_addr;
  logic [AW-1:0] pc_next_seq;
  logic          mem_done;

  seq_fsm #(
    .AW(AW), .START_PC(START_PC), .STEP(STEP)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .instr_done(instr_done), .trap_req(trap_req), .rti_req(rti_req),
    .irq_req(irq_req), .halt_req(halt_req),
    .mem_done(mem_done), .mem_rdata(mem_rdata),
    .start(start), .start_we(start_we), .vec_sel(vec_sel),
    .pc_next_seq(pc_next_seq),
    .pc(pc), .sup_mode(sup_mode), .int_en(int_en),
    .halted(halted), .busy(busy)
  );

  seq_vec_addr #(
    .AW(AW), .TW(TW), .SAVE_ADDR(SAVE_ADDR),
    .HANDLER_ADDR(HANDLER_ADDR), .TRAP_BASE(TRAP_BASE)
  ) u_vec (
    .sel(vec_sel), .trap_num(trap_num), .addr(start_addr)
  );

  seq_mem_port #(
    .AW(AW)
  ) u_port (
    .clk(clk), .rst(rst),
    .start(start), .start_we(start_we),
    .start_addr(start_addr), .start_wdata(pc_next_seq),
    .mem_ack(mem_ack),
    .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .done(mem_done)
  );

endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int AW        = 16,
  parameter int TW        = 4,
  parameter int SAVE_ADDR = 0,
  parameter int TRAP_BASE = 1000
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] mem_wdata,
  input logic          mem_ack,
  input logic [AW-1:0] pc,
  input logic          sup_mode,
  input logic          int_en,
  input logic          halted,
  input logic          busy
);

  localparam logic [AW-1:0] T_LO = AW'(TRAP_BASE);
  localparam logic [AW-1:0] T_HI = AW'(TRAP_BASE + (1 << TW) - 1);
  localparam logic [AW-1:0] S_AD = AW'(SAVE_ADDR);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R9

  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    halted && !busy |=> $stable(pc) && $stable(sup_mode) && !mem_req); // R3

  AST_SAVE_WRITE: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> !int_en && mem_addr == S_AD && mem_wdata == pc); // R4

  AST_SUP_FROM_TRAP: assert property (@(posedge clk) disable iff (rst)
    $rose(sup_mode) |-> $past(mem_ack && !mem_we && mem_addr >= T_LO && mem_addr <= T_HI)); // R11

  AST_EN_FROM_RTI: assert property (@(posedge clk) disable iff (rst)
    $rose(int_en) |-> $past(mem_ack && !mem_we && mem_addr == S_AD)); // R8

endmodule

bind irq_trap_seq seq_checker #(
  .AW(AW), .TW(TW), .SAVE_ADDR(SAVE_ADDR), .TRAP_BASE(TRAP_BASE)
) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
  .pc(pc), .sup_mode(sup_mode), .int_en(int_en),
  .halted(halted), .busy(busy)
);

// File: tb/tb_irq_trap_seq.sv
module tb_irq_trap_seq;

  localparam int AW = 16;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          instr_done = 1'b0, trap_req = 1'b0, rti_req = 1'b0;
  logic          irq_req = 1'b0, halt_req = 1'b0;
  logic [TW-1:0] trap_num = '0;
  logic          mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr, mem_wdata, mem_rdata, pc;
  logic          sup_mode, int_en, halted, busy;

  int total = 0;
  int bad   = 0;
  int lat   = 0;
  int cnt   = 0;
  logic [AW-1:0] mem [0:2047];

  always #4 clk = ~clk;

  irq_trap_seq dut (
    .clk(clk), .rst(rst), .instr_done(instr_done), .trap_req(trap_req),
    .trap_num(trap_num), .rti_req(rti_req), .irq_req(irq_req),
    .halt_req(halt_req), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .pc(pc), .sup_mode(sup_mode), .int_en(int_en),
    .halted(halted), .busy(busy)
  );

  // memory model with lat wait cycles before a one-cycle acknowledge
  always @(posedge clk) begin
    if (rst) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      cnt       <= 0;
    end else if (mem_req && !mem_ack) begin
      if (cnt >= lat) begin
        mem_ack   <= 1'b1;
        cnt       <= 0;
        mem_rdata <= mem[mem_addr[10:0]];
        if (mem_we) mem[mem_addr[10:0]] <= mem_wdata;
      end else begin
        cnt <= cnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  typedef struct packed {
    logic [1:0]  op;   // 0 step, 1 trap, 2 return
    logic [3:0]  num;
    logic        irq;
    logic [15:0] pc;
    logic        sup;
    logic        en;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'd0,  1'b1, 16'h0101, 1'b1, 1'b0},
    '{2'd0, 4'd0,  1'b0, 16'h0102, 1'b1, 1'b0},
    '{2'd2, 4'd0,  1'b0, 16'h0050, 1'b0, 1'b1},
    '{2'd0, 4'd0,  1'b0, 16'h0051, 1'b0, 1'b1},
    '{2'd0, 4'd0,  1'b1, 16'h0200, 1'b0, 1'b0},
    '{2'd0, 4'd0,  1'b0, 16'h0201, 1'b0, 1'b0},
    '{2'd2, 4'd0,  1'b0, 16'h0052, 1'b0, 1'b1},
    '{2'd1, 4'd3,  1'b0, 16'h0330, 1'b1, 1'b1},
    '{2'd0, 4'd0,  1'b0, 16'h0331, 1'b1, 1'b1},
    '{2'd1, 4'd15, 1'b0, 16'h03F0, 1'b1, 1'b1},
    '{2'd2, 4'd0,  1'b0, 16'h0052, 1'b0, 1'b1},
    '{2'd1, 4'd0,  1'b0, 16'h0300, 1'b1, 1'b1},
    '{2'd0, 4'd0,  1'b1, 16'h0200, 1'b1, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
  endtask

  task automatic fire(input logic st, input logic tr, input logic [TW-1:0] n,
                      input logic rt, input logic ir);
    @(negedge clk);
    instr_done = st; trap_req = tr; trap_num = n; rti_req = rt; irq_req = ir;
    @(negedge clk);
    instr_done = 0; trap_req = 0; rti_req = 0; irq_req = 0;
    wait_idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic  prev_en;
    string tag;
    for (int a = 0; a < 2048; a++) mem[a] = '0;
    mem[0] = 16'h0050;
    mem[1] = 16'h0200;
    for (int n = 0; n < 16; n++) mem[1000 + n] = 16'h0300 + 16'(16 * n);

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 pc", 32'(pc), 32'h0100);
    check("R1 sup", 32'(sup_mode), 1);
    check("R1 en", 32'(int_en), 0);
    check("R1 halted", 32'(halted), 0);
    check("R1 busy/req", 32'({busy, mem_req}), 0);

    // table walk: chained steps, traps and returns
    prev_en = 1'b0;
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].op == 2'd1)      tag = "R6/R11";
      else if (VECS[i].op == 2'd2) tag = "R8";
      else if (VECS[i].irq && prev_en) tag = "R4";
      else if (VECS[i].irq)        tag = "R5";
      else                         tag = "R2";
      fire(VECS[i].op == 2'd0, VECS[i].op == 2'd1, VECS[i].num,
           VECS[i].op == 2'd2, VECS[i].irq);
      check($sformatf("%s vec%0d pc", tag, i), 32'(pc), 32'(VECS[i].pc));
      check($sformatf("%s vec%0d sup", tag, i), 32'(sup_mode), 32'(VECS[i].sup));
      check($sformatf("%s vec%0d en", tag, i), 32'(int_en), 32'(VECS[i].en));
      prev_en = VECS[i].en;
    end
    // R4 saved PC is the advanced one
    check("R4 save word", 32'(mem[0]), 32'h0301);

    // R10 priority: return wins over trap and step
    fire(1'b1, 1'b1, 4'd2, 1'b1, 1'b0);
    check("R10 rti wins pc", 32'(pc), 32'h0301);
    check("R10 rti wins mode", 32'({sup_mode, int_en}), 32'b01);
    // R10 trap wins over step
    fire(1'b1, 1'b1, 4'd2, 1'b0, 1'b0);
    check("R10 trap wins pc", 32'(pc), 32'h0320);
    check("R10 trap wins sup", 32'(sup_mode), 1);

    // R7 / R9: strobes during a slow trap read are ignored
    lat = 3;
    @(negedge clk);
    trap_req = 1; trap_num = 4'd5;
    @(negedge clk);
    trap_req = 0;
    check("R9 req held", 32'(mem_req), 1);
    check("R9 addr", 32'(mem_addr), 32'd1005);
    instr_done = 1; irq_req = 1; rti_req = 1;
    repeat (2) @(negedge clk);
    check("R9 still held", 32'({mem_req, mem_addr}), 32'({1'b1, 16'd1005}));
    instr_done = 0; irq_req = 0; rti_req = 0;
    wait_idle();
    check("R7 pc", 32'(pc), 32'h0350);
    check("R7 mode/en", 32'({sup_mode, int_en}), 32'b11);
    check("R7 no save", 32'(mem[0]), 32'h0301);
    lat = 0;

    // R3 halt freezes the sequencer
    @(negedge clk);
    halt_req = 1;
    @(negedge clk);
    halt_req = 0;
    check("R3 halted", 32'(halted), 1);
    fire(1'b1, 1'b0, 4'd0, 1'b0, 1'b0);
    check("R3 step ignored", 32'(pc), 32'h0350);
    @(negedge clk);
    trap_req = 1; trap_num = 4'd1;
    @(negedge clk);
    trap_req = 0;
    check("R3 trap ignored", 32'({busy, mem_req}), 0);
    fire(1'b0, 1'b0, 4'd0, 1'b1, 1'b0);
    check("R3 rti ignored", 32'({pc, sup_mode, int_en}), 32'({16'h0350, 2'b11}));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule